// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block schedules the substrate discharge pulses that set the exposure time of a CCD sensor. It follows the field strobe (VD) and the line strobe (HD) from the sensor timing generator and works from three register values: a field count (`svd_i`), a line count (`shd_i`) and a burst position (`spl_i`). From these values it decides which field carries the discharge burst and which lines of that field get a pulse. It also decides which field performs the charge readout. Each qualifying line produces a one-cycle enable on `sub_pulse_o`. Pixel-clock placement of the pulse within the line and the analog level shifting are handled downstream.

An exposure cycle is `svd+1` fields long, indexed 0 to `svd`. The readout line, flagged by `ro_line_i` on the HD of the last line of a field, is acted on only in field `svd`. The register values are captured at the VD that follows a readout field, and the first VD after reset also captures them. `busy_o` tells the register block that a multi-field exposure is running and that new values would be ignored. `expo_o` is high while charge is being integrated. `ro_pulse_o` enables the readout pulse, unless `ro_inhibit_i` asks for plain vertical transfer.

The controller states are IDLE (after reset, until the first VD), STOP (shutter disabled), FAST (one-field exposure), PRE (before the burst field), BURST (the burst field) and POST (after the burst field). On every VD:
- IDLE, STOP and FAST always take the reload transition.
- PRE, BURST and POST take the reload transition if the field that is ending was the readout field. Otherwise they take the advance transition.
- The reload transition goes to STOP, FAST, BURST or PRE, depending on the enable and on the captured values.
- The advance transition goes to BURST when the new index equals the burst position, to POST when it is beyond the burst position, and stays in PRE otherwise.

Top module: `esh_seq`

## Requirements
- R1: With `shut_en_i` low at capture, no `sub_pulse_o` is produced and every field is a readout field, whatever `svd_i`, `shd_i` and `spl_i` hold.
- R2: In stopped mode `expo_o` rises on the first non-readout HD of a field and is low after the readout line.
- R3: With `svd_i` = 0, each field carries `shd+1` pulses on lines 0 to `shd`, counted from the first HD after VD (line 0). Each field is a readout field.
- R4: Bit 11 of `shd_i` is ignored, so only the low 11 bits count. When `shd` is at least the number of lines in a field, every line of the burst field gets a pulse.
- R5: `expo_o` goes high two cycles after the HD of the line whose index equals `shd` in the burst field. `expo_o` goes low one cycle after the HD of a performed readout line. If no pulse lands on line `shd`, `expo_o` stays low.
- R6: With `svd_i` ≥ 1, the cycle spans `svd+1` fields. The burst falls in field `spl`, and readout (a `ro_pulse_o`) occurs only in field `svd`. `ro_line_i` in any other field has no effect.
- R7: If `spl_i` is greater than `svd_i`, the burst field is field `svd`.
- R8: `busy_o` is high in the fields before the readout field of a low-speed exposure and low otherwise. Register changes made while busy take effect only at the VD after the readout field.
- R9: With `ro_inhibit_i` high, a readout line gives no `ro_pulse_o` but still ends the exposure (`expo_o` low).
- R10: An HD in the same cycle as VD is line 0 of the new field and is judged with the settings captured at that VD.
- R11: After reset all outputs are low, and no readout or pulse occurs before the first VD.
- R12: `ro_pulse_o` and each `sub_pulse_o` last one cycle and appear one cycle after their HD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd_i | input | 1 | Field start strobe, one cycle |
| hd_i | input | 1 | Line start strobe, one cycle |
| ro_line_i | input | 1 | Marks the HD of the readout line position |
| shut_en_i | input | 1 | 1 = shutter mode, 0 = stopped mode |
| ro_inhibit_i | input | 1 | Suppress the readout pulse |
| svd_i | input | 10 | Field count of the exposure |
| shd_i | input | 12 | Line count; bit 11 unused |
| spl_i | input | 10 | Burst field position |
| sub_pulse_o | output | 1 | Discharge pulse enable |
| expo_o | output | 1 | Exposure indicator |
| busy_o | output | 1 | Register update hold-off |
| ro_pulse_o | output | 1 | Readout pulse enable |

## Verification
The field reload at VD and the per-line decision at HD can fall in the same cycle. In that case the line decision must use the settings that the reload is capturing, not the state of the field that is ending. The bench provokes this by driving VD and HD together just after a stopped-mode field, with registers newly set to a one-field shutter with `shd` = 0. It judges the result by exactly one pulse on line 0 and a normal readout. The register freeze is tested by rewriting the registers in the middle of a three-field exposure. The bench confirms that the running exposure keeps its old schedule and that the new one starts after readout.

// File: rtl/esh_pkg.sv
`timescale 1ns/1ps
package esh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_FAST,
        ST_PRE,
        ST_BURST,
        ST_POST
    } fld_state_e;
endpackage

// File: rtl/esh_field_ctrl.sv
`timescale 1ns/1ps
module esh_field_ctrl
    import esh_pkg::*;
#(
    parameter int FLD_W = 10,
    parameter int SHD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vd_i,
    input  logic               shut_en_i,
    input  logic [FLD_W-1:0]   svd_i,
    input  logic [SHD_W-1:0]   shd_i,
    input  logic [FLD_W-1:0]   spl_i,
    output fld_state_e         eff_state_o,
    output logic [SHD_W-2:0]   eff_lim_o,
    output logic               ro_field_o,
    output logic               busy_o
);
    localparam int LIM_W = SHD_W - 1;

    fld_state_e       state_q, nx_state;
    logic [FLD_W-1:0] fidx_q, nx_fidx;
    logic [FLD_W-1:0] svd_q, nx_svd;
    logic [FLD_W-1:0] bpos_q, nx_bpos;
    logic [LIM_W-1:0] lim_q, nx_lim;
    logic [FLD_W-1:0] spl_clamp;
    logic             reload;
    logic             shd_msb_unused;

    assign shd_msb_unused = shd_i[SHD_W-1];
    assign spl_clamp      = (spl_i > svd_i) ? svd_i : spl_i;
    assign reload         = (state_q == ST_IDLE) || (fidx_q == svd_q);

    // next-state: reload transition or advance transition at VD
    always_comb begin
        nx_state = state_q;
        nx_fidx  = fidx_q;
        nx_svd   = svd_q;
        nx_bpos  = bpos_q;
        nx_lim   = lim_q;
        if (vd_i) begin
            if (reload) begin
                nx_fidx = '0;
                nx_lim  = shd_i[LIM_W-1:0];
                if (!shut_en_i) begin
                    nx_state = ST_STOP;
                    nx_svd   = '0;
                    nx_bpos  = '0;
                end else if (svd_i == '0) begin
                    nx_state = ST_FAST;
                    nx_svd   = '0;
                    nx_bpos  = '0;
                end else begin
                    nx_svd   = svd_i;
                    nx_bpos  = spl_clamp;
                    nx_state = (spl_clamp == '0) ? ST_BURST : ST_PRE;
                end
            end else begin
                nx_fidx = fidx_q + 1'b1;
                if (nx_fidx == bpos_q)
                    nx_state = ST_BURST;
                else if (nx_fidx > bpos_q)
                    nx_state = ST_POST;
                else
                    nx_state = ST_PRE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fidx_q  <= '0;
            svd_q   <= '0;
            bpos_q  <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= nx_state;
            fidx_q  <= nx_fidx;
            svd_q   <= nx_svd;
            bpos_q  <= nx_bpos;
            lim_q   <= nx_lim;
        end
    end

    // outputs
    always_comb begin
        eff_state_o = vd_i ? nx_state : state_q;
        eff_lim_o   = vd_i ? nx_lim : lim_q;
        ro_field_o  = (state_q != ST_IDLE) && (fidx_q == svd_q);
        unique case (state_q)
            ST_PRE, ST_BURST, ST_POST: busy_o = (fidx_q != svd_q);
            ST_IDLE, ST_STOP, ST_FAST: busy_o = 1'b0;
            default:                   busy_o = 1'b0;
        endcase
    end

    a_r6_fidx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fidx_q <= svd_q);
    a_r7_bpos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        bpos_q <= svd_q);
    a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(svd_q) && $stable(bpos_q) && $stable(lim_q)));
endmodule

// File: rtl/esh_line_gen.sv
`timescale 1ns/1ps
module esh_line_gen
    import esh_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int LIM_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vd_i,
    input  logic             hd_i,
    input  logic             ro_line_i,
    input  logic             ro_inhibit_i,
    input  fld_state_e       eff_state_i,
    input  logic [LIM_W-1:0] eff_lim_i,
    input  logic             ro_field_i,
    output logic             sub_pulse_o,
    output logic             expo_o,
    output logic             ro_pulse_o
);
    localparam int CW = (LINE_W > LIM_W) ? LINE_W : LIM_W;

    logic [LINE_W-1:0] lidx_q;
    logic [CW-1:0]     cur_ext, lim_ext;
    logic              burst_fld, sub_hit, last_hit, ro_hit, stop_hit, last_q;

    assign cur_ext = vd_i ? '0 : CW'(lidx_q);
    assign lim_ext = CW'(eff_lim_i);

    always_comb begin
        unique case (eff_state_i)
            ST_FAST, ST_BURST:                  burst_fld = 1'b1;
            ST_IDLE, ST_STOP, ST_PRE, ST_POST:  burst_fld = 1'b0;
            default:                            burst_fld = 1'b0;
        endcase
    end

    assign sub_hit  = hd_i && burst_fld && (cur_ext <= lim_ext);
    assign last_hit = sub_hit && (cur_ext == lim_ext);
    assign ro_hit   = hd_i && !vd_i && ro_line_i && ro_field_i;
    assign stop_hit = hd_i && (eff_state_i == ST_STOP) && !ro_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lidx_q      <= '0;
            sub_pulse_o <= 1'b0;
            last_q      <= 1'b0;
            ro_pulse_o  <= 1'b0;
            expo_o      <= 1'b0;
        end else begin
            if (vd_i)
                lidx_q <= hd_i ? LINE_W'(1) : '0;
            else if (hd_i && (lidx_q != '1))
                lidx_q <= lidx_q + 1'b1;
            sub_pulse_o <= sub_hit;
            last_q      <= last_hit;
            ro_pulse_o  <= ro_hit && !ro_inhibit_i;
            if (ro_hit)
                expo_o <= 1'b0;
            else if (last_q || stop_hit)
                expo_o <= 1'b1;
        end
    end

    a_r12_sub_follows_hd: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse_o |-> $past(hd_i));
    a_r12_ro_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ro_pulse_o |=> !ro_pulse_o);
    a_r9_ro_clears_expo: assert property (@(posedge clk) disable iff (!rst_n)
        ro_pulse_o |-> !expo_o);
endmodule

// File: rtl/esh_seq.sv
`timescale 1ns/1ps
module esh_seq
    import esh_pkg::*;
#(
    parameter int FLD_W  = 10,
    parameter int SHD_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vd_i,
    input  logic             hd_i,
    input  logic             ro_line_i,
    input  logic             shut_en_i,
    input  logic             ro_inhibit_i,
    input  logic [FLD_W-1:0] svd_i,
    input  logic [SHD_W-1:0] shd_i,
    input  logic [FLD_W-1:0] spl_i,
    output logic             sub_pulse_o,
    output logic             expo_o,
    output logic             busy_o,
    output logic             ro_pulse_o
);
    localparam int LIM_W = SHD_W - 1;

    fld_state_e       eff_state;
    logic [LIM_W-1:0] eff_lim;
    logic             ro_field;

    esh_field_ctrl #(.FLD_W(FLD_W), .SHD_W(SHD_W)) u_fld (
        .clk        (clk),
        .rst_n      (rst_n),
        .vd_i       (vd_i),
        .shut_en_i  (shut_en_i),
        .svd_i      (svd_i),
        .shd_i      (shd_i),
        .spl_i      (spl_i),
        .eff_state_o(eff_state),
        .eff_lim_o  (eff_lim),
        .ro_field_o (ro_field),
        .busy_o     (busy_o)
    );

    esh_line_gen #(.LINE_W(LINE_W), .LIM_W(LIM_W)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .vd_i        (vd_i),
        .hd_i        (hd_i),
        .ro_line_i   (ro_line_i),
        .ro_inhibit_i(ro_inhibit_i),
        .eff_state_i (eff_state),
        .eff_lim_i   (eff_lim),
        .ro_field_i  (ro_field),
        .sub_pulse_o (sub_pulse_o),
        .expo_o      (expo_o),
        .ro_pulse_o  (ro_pulse_o)
    );
endmodule

// File: tb/esh_seq_bench.sv
`timescale 1ns/1ps
module esh_seq_bench;
    localparam int NL = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, vd, hd, ro_line, en, inhibit;
    logic [9:0]  svd, spl;
    logic [11:0] shd;
    logic sub_pulse, expo, busy, ro_pulse;

    esh_seq u_esh_seq (
        .clk(clk), .rst_n(rst_n), .vd_i(vd), .hd_i(hd), .ro_line_i(ro_line),
        .shut_en_i(en), .ro_inhibit_i(inhibit), .svd_i(svd), .shd_i(shd),
        .spl_i(spl), .sub_pulse_o(sub_pulse), .expo_o(expo), .busy_o(busy),
        .ro_pulse_o(ro_pulse)
    );

    int checks = 0, errors = 0;
    int cur_line = 0;
    int m_subs, m_first, m_last, m_ro;
    int m_pre, m_post, m_busy;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sub_pulse) begin
                if (m_subs == 0) m_first = cur_line;
                m_last = cur_line;
                m_subs++;
            end
            if (ro_pulse) m_ro++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_field(bit coin);
        m_subs = 0; m_ro = 0; m_first = -1; m_last = -1;
        @(negedge clk);
        cur_line = 0;
        vd = 1'b1; hd = coin;
        @(negedge clk);
        vd = 1'b0; hd = 1'b0;
        for (int l = 0; l < NL; l++) begin
            if (!(l == 0 && coin)) begin
                @(negedge clk);
                cur_line = l;
                if (l == NL - 1) m_pre = expo;
                hd = 1'b1; ro_line = (l == NL - 1);
                @(negedge clk);
                hd = 1'b0; ro_line = 1'b0;
            end
            repeat (4) @(negedge clk);
            if (l == 1) m_busy = busy;
        end
        m_post = expo;
    endtask

    task automatic t_reset;
        chk("R11 sub at reset", sub_pulse, 0);
        chk("R11 expo at reset", expo, 0);
        chk("R11 busy at reset", busy, 0);
        chk("R11 ro at reset", ro_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        hd = 1'b1; ro_line = 1'b1;
        @(negedge clk);
        hd = 1'b0; ro_line = 1'b0;
        chk("R11 no readout before VD", ro_pulse, 0);
        chk("R11 no pulse before VD", sub_pulse, 0);
    endtask

    task automatic t_stop;
        en = 0; svd = 10'd5; shd = 12'd3; spl = 10'd2;
        for (int f = 0; f < 2; f++) begin
            run_field(0);
            chk("R1 stop no pulses", m_subs, 0);
            chk("R1 stop readout each field", m_ro, 1);
            chk("R2 stop expo before readout", m_pre, 1);
            chk("R2 stop expo after readout", m_post, 0);
            chk("R8 stop not busy", m_busy, 0);
        end
    endtask

    task automatic t_fast;
        en = 1; svd = 10'd0; shd = 12'd2; spl = 10'd0;
        run_field(0);
        chk("R3 fast pulse count", m_subs, 3);
        chk("R3 fast first line", m_first, 0);
        chk("R3 fast last line", m_last, 2);
        chk("R3 fast readout", m_ro, 1);
        chk("R5 expo before readout", m_pre, 1);
        chk("R5 expo after readout", m_post, 0);
    endtask

    task automatic t_dummy_msb;
        shd = 12'h802;
        run_field(0);
        chk("R4 msb ignored count", m_subs, 3);
        shd = 12'h7FF;
        run_field(0);
        chk("R4 saturated every line", m_subs, NL);
        chk("R5 no expo without last pulse", m_pre, 0);
    endtask

    task automatic t_slow_freeze;
        svd = 10'd2; spl = 10'd1; shd = 12'd1;
        run_field(0);
        chk("R6 field0 pulses", m_subs, 0);
        chk("R6 field0 no readout", m_ro, 0);
        chk("R8 field0 busy", m_busy, 1);
        chk("R5 field0 expo low", m_pre, 0);
        svd = 10'd0; shd = 12'd4; spl = 10'd0;
        run_field(0);
        chk("R6 field1 burst count", m_subs, 2);
        chk("R6 field1 no readout", m_ro, 0);
        chk("R8 field1 busy", m_busy, 1);
        chk("R5 field1 expo high", m_pre, 1);
        run_field(0);
        chk("R8 frozen field2 pulses", m_subs, 0);
        chk("R6 field2 readout", m_ro, 1);
        chk("R8 readout field not busy", m_busy, 0);
        chk("R5 field2 expo held", m_pre, 1);
        chk("R5 field2 expo cleared", m_post, 0);
        run_field(0);
        chk("R8 new values after readout", m_subs, 5);
        chk("R3 readout after reload", m_ro, 1);
    endtask

    task automatic t_clamp;
        svd = 10'd1; spl = 10'd5; shd = 12'd0;
        run_field(0);
        chk("R7 clamp field0 pulses", m_subs, 0);
        chk("R7 clamp field0 no readout", m_ro, 0);
        chk("R8 clamp field0 busy", m_busy, 1);
        run_field(0);
        chk("R7 clamp burst in last field", m_subs, 1);
        chk("R7 clamp readout", m_ro, 1);
        chk("R8 clamp last field not busy", m_busy, 0);
    endtask

    task automatic t_inhibit;
        en = 0; inhibit = 1;
        run_field(0);
        chk("R9 readout pulse blocked", m_ro, 0);
        chk("R9 expo before line", m_pre, 1);
        chk("R9 exposure still ended", m_post, 0);
        inhibit = 0;
    endtask

    task automatic t_coincide;
        en = 1; svd = 10'd0; shd = 12'd0;
        run_field(1);
        chk("R10 coincident HD pulses", m_subs, 1);
        chk("R10 coincident HD is line 0", m_first, 0);
        chk("R10 readout", m_ro, 1);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; vd = 0; hd = 0; ro_line = 0; en = 0; inhibit = 0;
        svd = '0; shd = '0; spl = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_stop();
        t_fast();
        t_dummy_msb();
        t_slow_freeze();
        t_clamp();
        t_inhibit();
        t_coincide();
        done = 1;
        summary();
        $finish;
    end
endmodule